// File: doc/BRIEF.md
# Die-Aligned Reed-Solomon Codec for DRAM Words

This block guards a 32-bit user word on its way into and out of DRAM. Its encoder turns the word into a 48-bit stored word. The stored word is a Reed-Solomon codeword of twelve 4-bit symbols: eight carry data and four carry check information. The stored word is split across six byte-wide memory dice. Each die holds exactly two neighbouring symbols, so damage confined to one die touches at most two symbols.

The decoder takes a 48-bit word read back from memory. It forms four syndromes and solves directly for up to two symbol errors. It returns the repaired 32-bit word with two flags: one for a repair and one for a failure. A third output tells a scrub engine that the stored word was not a clean codeword and may need rewriting. Encoder and decoder work side by side. Each registers its result, so outputs appear one clock after the inputs are presented.

Top module: `rs12_die_codec`

## Requirements
- R1: `enc_word_o[31:0]` equals the `enc_data_i` presented at the previous rising clock edge: data nibble k sits in bits 4k+3:4k.
- R2: `enc_word_o` is a codeword. Symbol k is bits 4k+3:4k of the word. It is the coefficient of x^(k+4) for k<8 and of x^(k-8) for k of 8 to 11. With arithmetic in GF(16) reduced by x^4+x+1, the polynomial is zero at alpha^0, alpha^1, alpha^2 and alpha^3, where alpha is 4'h2.
- R3: All outputs are zero while `rst_n` is low. After reset, every decoder output reflects the `dec_word_i` sampled at the previous rising edge.
- R4: A read word whose four syndromes are all zero is passed through unchanged, with no flag raised.
- R5: Any nonzero corruption confined to one die is repaired, and `dec_fixed_o` is raised. Die d holds bits 8d+7:8d.
- R6: Two single-bit flips in two different dice are repaired, and `dec_fixed_o` is raised.
- R7: Any error pattern touching at most two symbols is repaired, and `dec_fixed_o` is raised.
- R8: `dec_syn_nz_o` is high exactly when the read word is not a codeword. Neither `dec_fixed_o` nor `dec_fail_o` is ever high while it is low.
- R9: When no pattern of at most two symbol errors inside the twelve symbols explains the syndromes, the decoder raises `dec_fail_o` and returns the read data bits unmodified. `dec_fixed_o` and `dec_fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 32 | User word to encode |
| enc_word_o | output | 48 | Stored word: data in bits 31:0, check symbols in bits 47:32 |
| dec_word_i | input | 48 | Word read back from memory |
| dec_data_o | output | 32 | Repaired user word |
| dec_fixed_o | output | 1 | One or two symbols were repaired |
| dec_fail_o | output | 1 | Error beyond correction; data passed through |
| dec_syn_nz_o | output | 1 | Read word was not a clean codeword |

## Verification
The in-line properties are checked on every cycle. They cover the following:
- the encoder keeps the data in place;
- the two flags never appear together;
- neither flag appears without a nonzero syndrome;
- a clean or failed word leaves the data bits untouched.

Only the bench's scenarios can show that the check symbols form a valid codeword. The same holds for three kinds of repair: each of the 1530 single-die corruptions, each of the 960 cross-die bit pairs, and random one- and two-symbol errors. Finally, the bench's exhaustive weight-two search is compared with the decoder's fail decision on heavier damage.

// File: rtl/rs12_die_codec.sv
module rs12_die_codec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] enc_data_i,
  output logic [47:0] enc_word_o,
  input  logic [47:0] dec_word_i,
  output logic [31:0] dec_data_o,
  output logic        dec_fixed_o,
  output logic        dec_fail_o,
  output logic        dec_syn_nz_o
);
  localparam int NSYM = 12;
  localparam int NDAT = 8;
  localparam logic [3:0] G0 = 4'hC, G1 = 4'h1, G2 = 4'h3, G3 = 4'hF;

  function automatic logic [3:0] gmul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p, t;
    p = '0;
    t = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p ^= t;
      t = {t[2:0], 1'b0} ^ (t[3] ? 4'h3 : 4'h0);
    end
    return p;
  endfunction

  function automatic logic [3:0] gexp(input int n);
    logic [3:0] v;
    v = 4'h1;
    for (int i = 0; i < 15; i++) if (i < n) v = gmul(v, 4'h2);
    return v;
  endfunction

  function automatic int glog(input logic [3:0] a);
    int l;
    l = 0;
    for (int i = 0; i < 15; i++) if (gexp(i) == a) l = i;
    return l;
  endfunction

  function automatic logic [3:0] gdiv(input logic [3:0] a, input logic [3:0] b);
    return (b == 4'h0) ? 4'h0 : gmul(a, gexp((15 - glog(b)) % 15));
  endfunction

  logic [47:0] enc_next;
  logic [31:0] fix_data;
  logic        syn_nz, fix, fail;

  always_comb begin
    logic [3:0] q0, q1, q2, q3, fb;
    q0 = '0; q1 = '0; q2 = '0; q3 = '0;
    for (int k = NDAT - 1; k >= 0; k--) begin
      fb = enc_data_i[4*k +: 4] ^ q3;
      q3 = q2 ^ gmul(fb, G3);
      q2 = q1 ^ gmul(fb, G2);
      q1 = q0 ^ gmul(fb, G1);
      q0 = gmul(fb, G0);
    end
    enc_next = {q3, q2, q1, q0, enc_data_i};
  end

  always_comb begin
    logic [3:0] r [NSYM];
    logic [3:0] e [NSYM];
    logic [3:0] s [4];
    logic [3:0] det, l1, l2, xi, x1, x2, y1, xs;
    int cnt, p1, p2, ls;
    for (int k = 0; k < NSYM; k++) r[(k < NDAT) ? k + 4 : k - NDAT] = dec_word_i[4*k +: 4];
    for (int j = 0; j < 4; j++) s[j] = '0;
    for (int i = NSYM - 1; i >= 0; i--)
      for (int j = 0; j < 4; j++) s[j] = gmul(s[j], gexp(j)) ^ r[i];
    for (int i = 0; i < NSYM; i++) e[i] = '0;
    det = gmul(s[1], s[1]) ^ gmul(s[0], s[2]);
    l1  = gdiv(gmul(s[2], s[1]) ^ gmul(s[0], s[3]), det);
    l2  = gdiv(gmul(s[1], s[3]) ^ gmul(s[2], s[2]), det);
    cnt = 0; p1 = 0; p2 = 0;
    for (int i = 0; i < NSYM; i++) begin
      xi = gexp((15 - i) % 15);
      if ((4'h1 ^ gmul(l1, xi) ^ gmul(l2, gmul(xi, xi))) == 4'h0) begin
        if (cnt == 0) p1 = i;
        else p2 = i;
        cnt++;
      end
    end
    x1 = gexp(p1);
    x2 = gexp(p2);
    y1 = gdiv(s[1] ^ gmul(s[0], x2), x1 ^ x2);
    xs = gdiv(s[1], s[0]);
    ls = glog(xs);
    syn_nz = (s[0] | s[1] | s[2] | s[3]) != 4'h0;
    fix = 1'b0;
    fail = 1'b0;
    if (syn_nz) begin
      if (det != 4'h0) begin
        if (cnt == 2) begin
          e[p1] = y1;
          e[p2] = y1 ^ s[0];
          fix = 1'b1;
        end else fail = 1'b1;
      end else if (s[0] != 4'h0 && s[1] != 4'h0 && s[2] == gmul(s[1], xs) &&
                   s[3] == gmul(s[2], xs) && ls < NSYM) begin
        e[ls] = s[0];
        fix = 1'b1;
      end else fail = 1'b1;
    end
    for (int k = 0; k < NDAT; k++) fix_data[4*k +: 4] = dec_word_i[4*k +: 4] ^ e[k+4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_word_o   <= '0;
      dec_data_o   <= '0;
      dec_fixed_o  <= 1'b0;
      dec_fail_o   <= 1'b0;
      dec_syn_nz_o <= 1'b0;
    end else begin
      enc_word_o   <= enc_next;
      dec_data_o   <= fix_data;
      dec_fixed_o  <= fix;
      dec_fail_o   <= fail;
      dec_syn_nz_o <= syn_nz;
    end
  end

  // R1
  enc_data_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> enc_word_o[31:0] == $past(enc_data_i));
  // R9
  no_both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_fixed_o && dec_fail_o));
  // R8
  flag_needs_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fixed_o || dec_fail_o) |-> dec_syn_nz_o);
  // R4
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (dec_syn_nz_o || dec_data_o == $past(dec_word_i[31:0])));
  // R9
  fail_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (!dec_fail_o || dec_data_o == $past(dec_word_i[31:0])));
endmodule

// File: tb/tb_rs12_die_codec.sv
`timescale 1ns/1ps
module tb_rs12_die_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] enc_data_i;
  logic [47:0] enc_word_o;
  logic [47:0] dec_word_i;
  logic [31:0] dec_data_o;
  logic        dec_fixed_o, dec_fail_o, dec_syn_nz_o;

  rs12_die_codec dut (
    .clk(clk), .rst_n(rst_n), .enc_data_i(enc_data_i), .enc_word_o(enc_word_o),
    .dec_word_i(dec_word_i), .dec_data_o(dec_data_o), .dec_fixed_o(dec_fixed_o),
    .dec_fail_o(dec_fail_o), .dec_syn_nz_o(dec_syn_nz_o)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int exp_t [15];
  int log_t [16];
  logic [15:0] esyn [12][16];

  function automatic logic [15:0] syn(input logic [47:0] w);
    logic [15:0] s;
    s = '0;
    for (int k = 0; k < 12; k++) begin
      int v, d;
      v = int'(w[4*k +: 4]);
      d = (k < 8) ? k + 4 : k - 8;
      if (v != 0)
        for (int j = 0; j < 4; j++) s[4*j +: 4] ^= 4'(exp_t[(log_t[v] + d*j) % 15]);
    end
    return s;
  endfunction

  function automatic void refdec(input logic [47:0] w, output logic [31:0] d,
                                 output logic c, output logic u, output logic n);
    logic [15:0] s;
    logic [47:0] e;
    bit found;
    s = syn(w);
    n = (s != 16'h0);
    found = 1'b0;
    e = '0;
    if (n) begin
      for (int p = 0; p < 12; p++)
        for (int v = 1; v < 16; v++)
          if (!found && esyn[p][v] == s) begin found = 1'b1; e = 48'(v) << (4*p); end
      for (int p = 0; p < 12; p++)
        for (int q = p + 1; q < 12; q++)
          for (int v = 1; v < 16; v++)
            for (int x = 1; x < 16; x++)
              if (!found && (esyn[p][v] ^ esyn[q][x]) == s) begin
                found = 1'b1;
                e = (48'(v) << (4*p)) | (48'(x) << (4*q));
              end
    end
    c = found;
    u = n && !found;
    d = w[31:0] ^ e[31:0];
  endfunction

  task automatic chk(input string req, input bit ok, input logic [47:0] act, input logic [47:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic enc_step(input logic [31:0] d, output logic [47:0] w);
    enc_data_i = d;
    @(negedge clk);
    w = enc_word_o;
    chk("R1", w[31:0] == d, 48'(w[31:0]), 48'(d));
    chk("R2", syn(w) == 16'h0, 48'(syn(w)), 48'h0);
  endtask

  task automatic dec_step(input string req, input logic [47:0] w, input logic [31:0] orig, input bit must_fix);
    logic [31:0] ed;
    logic ec, eu, en;
    refdec(w, ed, ec, eu, en);
    dec_word_i = w;
    @(negedge clk);
    chk(req, {dec_data_o, dec_fixed_o, dec_fail_o, dec_syn_nz_o} == {ed, ec, eu, en},
        48'({dec_data_o, dec_fixed_o, dec_fail_o, dec_syn_nz_o}), 48'({ed, ec, eu, en}));
    if (must_fix)
      chk(req, dec_data_o == orig && dec_fixed_o && !dec_fail_o,
          48'({dec_data_o, dec_fixed_o}), 48'({orig, 1'b1}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] cw, w;
    logic [31:0] dv;
    exp_t[0] = 1;
    log_t[0] = 0;
    log_t[1] = 0;
    for (int i = 1; i < 15; i++) begin
      int t;
      t = exp_t[i-1] << 1;
      if (t >= 16) t ^= 19;
      exp_t[i] = t;
      log_t[t] = i;
    end
    for (int p = 0; p < 12; p++)
      for (int v = 0; v < 16; v++) esyn[p][v] = syn(48'(v) << (4*p));

    enc_data_i = 32'hFFFF_FFFF;
    dec_word_i = '1;
    repeat (3) @(negedge clk);
    chk("R3", {enc_word_o, dec_data_o, dec_fixed_o, dec_fail_o, dec_syn_nz_o} == '0,
        enc_word_o, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R8: several data patterns, then clean read back
    foreach (dv_list[i]) begin
      enc_step(dv_list[i], cw);
      dec_step("R4 R8", cw, dv_list[i], 1'b0);
      chk("R4", dec_data_o == dv_list[i] && !dec_syn_nz_o, 48'(dec_data_o), 48'(dv_list[i]));
    end
    for (int i = 0; i < 16; i++) begin
      dv = $urandom;
      enc_step(dv, cw);
      dec_step("R4 R8", cw, dv, 1'b0);
    end

    // R5: every nonzero pattern inside every die
    enc_step(32'h3C96_A50F, cw);
    for (int d = 0; d < 6; d++)
      for (int p = 1; p < 256; p++)
        dec_step("R5", cw ^ (48'(p) << (8*d)), 32'h3C96_A50F, 1'b1);

    // R6: every pair of single-bit flips in two different dice
    enc_step(32'h0F1E_2D3C, cw);
    for (int a = 0; a < 48; a++)
      for (int b = a + 1; b < 48; b++)
        if (a / 8 != b / 8)
          dec_step("R6", cw ^ (48'(1) << a) ^ (48'(1) << b), 32'h0F1E_2D3C, 1'b1);

    // R7: random one- or two-symbol errors on random data
    for (int i = 0; i < 300; i++) begin
      int p, q;
      dv = $urandom;
      enc_step(dv, cw);
      p = $urandom % 12;
      q = (p + 1 + $urandom % 11) % 12;
      w = cw ^ (48'(1 + $urandom % 15) << (4*p));
      if (i % 2 == 1) w = w ^ (48'(1 + $urandom % 15) << (4*q));
      dec_step("R7", w, dv, 1'b1);
    end

    // R9: three- and four-symbol damage, judged by exhaustive search
    for (int i = 0; i < 120; i++) begin
      int p, q, r;
      dv = $urandom;
      enc_step(dv, cw);
      p = $urandom % 12;
      q = (p + 1 + $urandom % 11) % 12;
      r = (q + 1 + $urandom % 11) % 12;
      if (r == p) r = (r + 1) % 12;
      if (r == q) r = (r + 1) % 12;
      if (r == p) r = (r + 1) % 12;
      w = cw ^ (48'(1 + $urandom % 15) << (4*p)) ^ (48'(1 + $urandom % 15) << (4*q))
             ^ (48'(1 + $urandom % 15) << (4*r));
      if (i % 4 == 0) w = cw ^ (48'hFFFF << (16 * (i % 3)));
      dec_step("R9", w, dv, 1'b0);
      chk("R9", !(dec_fixed_o && dec_fail_o) && (!dec_fail_o || dec_data_o == w[31:0]),
          48'(dec_data_o), 48'(w[31:0]));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [31:0] dv_list [5] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5A5_5A5A, 32'h8000_0001};
endmodule